// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Word Shape

This block is a true dual-port memory of 36 Kbit. Port A and port B each have their own enable, write enable, reset, word-shape select, address, write data and read data. Both ports address one shared storage. A word written in one shape can be read back in another. The storage has 32 Kbit of data bits, kept as 1024 rows of 32 bits, and 4 Kbit of parity bits, kept as 1024 rows of 4 bits. Parity bits are stored and returned only in the three widest shapes.

Each port picks its shape through a 3-bit code that it may change from one access to the next. Parameters set the active level of each port's enable, write enable and reset, each one chosen separately. A further parameter picks the clock edge on which the whole block operates. All reads are synchronous, and the read data register of a port can be cleared without touching the stored contents. When both ports write the same stored bit at the same edge, port A's value is kept.

Top module: `dpram_multi_shape`

## Requirements
- R1: The shape code selects the word layout: 0 = 1K x 36 (32 data + 4 parity), 1 = 2K x 18 (16 + 2), 2 = 4K x 9 (8 + 1), 3 = 8K x 4, 4 = 16K x 2, 5 = 32K x 1. Codes 6 and 7 behave as code 5.
- R2: On write data and read data, the data bits sit at bit 0 upward, and the parity bits follow directly above them. Every read data bit above the selected word is 0, and write data bits above the selected word are ignored.
- R3: For shape code k, the storage row is address >> k and the slice is s = address[k-1:0]. The port reaches data row bits [s*w +: w] for a data width w, and parity row bits [s*p +: p] for a parity width p. A write in one shape can therefore be read back in any other shape.
- R4: Read data shows the word at the address present at an enabled clock edge right after that edge, and not before it.
- R5: A write changes only the selected slice of the row. A read on the same port during a write returns the contents as they were before the write. The storage starts as all zeros.
- R6: While a port's enable is inactive, that port writes nothing and its read data holds its value.
- R7: An active reset at a clock edge sets that port's read data to 0 and leaves the stored contents unchanged.
- R8: When both ports write the same stored bit at one edge, port A's value is stored. Bits written by only one port take that port's value.
- R9: The parameters `*_EN_HIGH`, `*_WE_HIGH` and `*_RST_HIGH` give the active level of each control for each port. A value of 0 makes that control active when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_rst | input | 1 | Port A read data clear |
| a_shape | input | 3 | Port A word-shape code |
| a_addr | input | 15 | Port A address in units of the selected word |
| a_din | input | 36 | Port A write data |
| a_dout | output | 36 | Port A read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_rst | input | 1 | Port B read data clear |
| b_shape | input | 3 | Port B word-shape code |
| b_addr | input | 15 | Port B address in units of the selected word |
| b_din | input | 36 | Port B write data |
| b_dout | output | 36 | Port B read data |

## Verification
The assertions assume that every control input already has a known level at the first clock edge. They also assume that a narrow read is recognised from the shape code sampled together with an enabled, non-reset edge. The stimulus changes every input half a period away from the active edge and holds it through that edge. It starts with both resets active for several cycles. Port B's controls are driven active-low, to match the parameter values used on the bench instance.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int unsigned SHAPE_W = 3;

  typedef enum logic [SHAPE_W-1:0] {
    SHAPE_X36 = 3'd0,
    SHAPE_X18 = 3'd1,
    SHAPE_X9  = 3'd2,
    SHAPE_X4  = 3'd3,
    SHAPE_X2  = 3'd4,
    SHAPE_X1  = 3'd5
  } shape_e;

  // Fold reserved codes onto the narrowest legal shape.
  function automatic logic [SHAPE_W-1:0] shape_level(input logic [SHAPE_W-1:0] code,
                                                      input int unsigned max_level);
    if (int'(code) > int'(max_level)) return SHAPE_W'(max_level);
    return code;
  endfunction
endpackage

// File: rtl/dpram_wr_map.sv
module dpram_wr_map
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAR_W  = 4,
  parameter int unsigned ROWS   = 1024
) (
  input  logic [SHAPE_W-1:0]                      shape,
  input  logic [$clog2(ROWS)+$clog2(DATA_W)-1:0] addr,
  input  logic [DATA_W+PAR_W-1:0]                 din,
  output logic [$clog2(ROWS)-1:0]                 row,
  output logic [SHAPE_W-1:0]                      level,
  output logic [$clog2(DATA_W)-1:0]               slice,
  output logic [DATA_W-1:0]                       dmask,
  output logic [DATA_W-1:0]                       dval,
  output logic [PAR_W-1:0]                        pmask,
  output logic [PAR_W-1:0]                        pval
);
  localparam int unsigned ROW_AW  = $clog2(ROWS);
  localparam int unsigned SUB_W   = $clog2(DATA_W);
  localparam int unsigned PAR_LVL = $clog2(PAR_W);

  int unsigned        dw_i, off_i, pw_i, poff_i;
  logic [DATA_W-1:0]  ones_d;
  logic [PAR_W-1:0]   ones_p;

  always_comb begin
    level  = shape_level(shape, SUB_W);
    row    = ROW_AW'(addr >> level);
    slice  = SUB_W'(addr) & SUB_W'((1 << level) - 1);
    dw_i   = DATA_W >> level;
    off_i  = int'(slice) * dw_i;
    ones_d = {DATA_W{1'b1}} >> (DATA_W - dw_i);
    dmask  = ones_d << off_i;
    dval   = (din[DATA_W-1:0] & ones_d) << off_i;
    pw_i   = 0;
    poff_i = 0;
    ones_p = '0;
    pmask  = '0;
    pval   = '0;
    if (int'(level) <= PAR_LVL) begin
      pw_i   = PAR_W >> level;
      poff_i = int'(slice) * pw_i;
      ones_p = {PAR_W{1'b1}} >> (PAR_W - pw_i);
      pmask  = ones_p << poff_i;
      pval   = (PAR_W'(din >> dw_i) & ones_p) << poff_i;
    end
  end
endmodule

// File: rtl/dpram_rd_extract.sv
module dpram_rd_extract
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAR_W  = 4
) (
  input  logic [SHAPE_W-1:0]        level,
  input  logic [$clog2(DATA_W)-1:0] slice,
  input  logic [DATA_W-1:0]         row_d,
  input  logic [PAR_W-1:0]          row_p,
  output logic [DATA_W+PAR_W-1:0]   dout
);
  localparam int unsigned PORT_W  = DATA_W + PAR_W;
  localparam int unsigned PAR_LVL = $clog2(PAR_W);

  int unsigned       dw_i, off_i, pw_i, poff_i;
  logic [DATA_W-1:0] ones_d, dsel;
  logic [PAR_W-1:0]  ones_p, psel;

  always_comb begin
    dw_i   = DATA_W >> level;
    off_i  = int'(slice) * dw_i;
    ones_d = {DATA_W{1'b1}} >> (DATA_W - dw_i);
    dsel   = (row_d >> off_i) & ones_d;
    pw_i   = 0;
    poff_i = 0;
    ones_p = '0;
    psel   = '0;
    if (int'(level) <= PAR_LVL) begin
      pw_i   = PAR_W >> level;
      poff_i = int'(slice) * pw_i;
      ones_p = {PAR_W{1'b1}} >> (PAR_W - pw_i);
      psel   = (row_p >> poff_i) & ones_p;
    end
    dout = PORT_W'(dsel) | (PORT_W'(psel) << dw_i);
  end
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PAR_W  = 4,
  parameter int unsigned ROWS   = 1024
) (
  input  logic                    clk,
  input  logic                    wr_a,
  input  logic                    rd_a,
  input  logic                    clr_a,
  input  logic [$clog2(ROWS)-1:0] row_a,
  input  logic [DATA_W-1:0]       dmask_a,
  input  logic [DATA_W-1:0]       dval_a,
  input  logic [PAR_W-1:0]        pmask_a,
  input  logic [PAR_W-1:0]        pval_a,
  output logic [DATA_W-1:0]       rdat_a,
  output logic [PAR_W-1:0]        rpar_a,
  input  logic                    wr_b,
  input  logic                    rd_b,
  input  logic                    clr_b,
  input  logic [$clog2(ROWS)-1:0] row_b,
  input  logic [DATA_W-1:0]       dmask_b,
  input  logic [DATA_W-1:0]       dval_b,
  input  logic [PAR_W-1:0]        pmask_b,
  input  logic [PAR_W-1:0]        pval_b,
  output logic [DATA_W-1:0]       rdat_b,
  output logic [PAR_W-1:0]        rpar_b
);
  logic [DATA_W-1:0] dmem [ROWS];
  logic [PAR_W-1:0]  pmem [ROWS];

  initial begin
    for (int r = 0; r < int'(ROWS); r++) begin
      dmem[r] = '0;
      pmem[r] = '0;
    end
  end

  // Per-bit write enables; port A is applied last so it wins a shared bit.
  always_ff @(posedge clk) begin
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (wr_b && dmask_b[i]) dmem[row_b][i] <= dval_b[i];
      if (wr_a && dmask_a[i]) dmem[row_a][i] <= dval_a[i];
    end
    for (int j = 0; j < int'(PAR_W); j++) begin
      if (wr_b && pmask_b[j]) pmem[row_b][j] <= pval_b[j];
      if (wr_a && pmask_a[j]) pmem[row_a][j] <= pval_a[j];
    end
  end

  // Read registers sample the array before this edge's writes land.
  always_ff @(posedge clk) begin
    if (clr_a) begin
      rdat_a <= '0;
      rpar_a <= '0;
    end else if (rd_a) begin
      rdat_a <= dmem[row_a];
      rpar_a <= pmem[row_a];
    end
  end

  always_ff @(posedge clk) begin
    if (clr_b) begin
      rdat_b <= '0;
      rpar_b <= '0;
    end else if (rd_b) begin
      rdat_b <= dmem[row_b];
      rpar_b <= pmem[row_b];
    end
  end
endmodule

// File: rtl/dpram_multi_shape.sv
module dpram_multi_shape
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PAR_W       = 4,
  parameter int unsigned ROWS        = 1024,
  parameter bit          CLK_FALLING = 1'b0,
  parameter bit          A_EN_HIGH   = 1'b1,
  parameter bit          A_WE_HIGH   = 1'b1,
  parameter bit          A_RST_HIGH  = 1'b1,
  parameter bit          B_EN_HIGH   = 1'b1,
  parameter bit          B_WE_HIGH   = 1'b1,
  parameter bit          B_RST_HIGH  = 1'b1,
  localparam int unsigned ADDR_W     = $clog2(ROWS) + $clog2(DATA_W),
  localparam int unsigned PORT_W     = DATA_W + PAR_W
) (
  input  logic               clk,
  input  logic               a_en,
  input  logic               a_we,
  input  logic               a_rst,
  input  logic [SHAPE_W-1:0] a_shape,
  input  logic [ADDR_W-1:0]  a_addr,
  input  logic [PORT_W-1:0]  a_din,
  output logic [PORT_W-1:0]  a_dout,
  input  logic               b_en,
  input  logic               b_we,
  input  logic               b_rst,
  input  logic [SHAPE_W-1:0] b_shape,
  input  logic [ADDR_W-1:0]  b_addr,
  input  logic [PORT_W-1:0]  b_din,
  output logic [PORT_W-1:0]  b_dout
);
  localparam int unsigned ROW_AW = $clog2(ROWS);
  localparam int unsigned SUB_W  = $clog2(DATA_W);
  localparam logic [1:0]  EN_HI  = {B_EN_HIGH, A_EN_HIGH};
  localparam logic [1:0]  WE_HI  = {B_WE_HIGH, A_WE_HIGH};
  localparam logic [1:0]  RST_HI = {B_RST_HIGH, A_RST_HIGH};

  logic gclk;
  assign gclk = CLK_FALLING ? ~clk : clk;

  logic               en_v [2];
  logic               we_v [2];
  logic               rst_v [2];
  logic [SHAPE_W-1:0] shape_v [2];
  logic [ADDR_W-1:0]  addr_v [2];
  logic [PORT_W-1:0]  din_v [2];
  logic [PORT_W-1:0]  dout_v [2];

  logic               wr_v [2];
  logic               rd_v [2];
  logic               clr_v [2];
  logic [ROW_AW-1:0]  row_v [2];
  logic [SHAPE_W-1:0] lvl_v [2];
  logic [SUB_W-1:0]   sub_v [2];
  logic [DATA_W-1:0]  dmask_v [2];
  logic [DATA_W-1:0]  dval_v [2];
  logic [PAR_W-1:0]   pmask_v [2];
  logic [PAR_W-1:0]   pval_v [2];
  logic [DATA_W-1:0]  rdat_v [2];
  logic [PAR_W-1:0]   rpar_v [2];

  assign en_v[0] = a_en;       assign en_v[1] = b_en;
  assign we_v[0] = a_we;       assign we_v[1] = b_we;
  assign rst_v[0] = a_rst;     assign rst_v[1] = b_rst;
  assign shape_v[0] = a_shape; assign shape_v[1] = b_shape;
  assign addr_v[0] = a_addr;   assign addr_v[1] = b_addr;
  assign din_v[0] = a_din;     assign din_v[1] = b_din;
  assign a_dout = dout_v[0];
  assign b_dout = dout_v[1];

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic               en_act, we_act, rst_act;
    logic [SHAPE_W-1:0] lvl_q;
    logic [SUB_W-1:0]   sub_q;

    assign en_act   = (en_v[p] == EN_HI[p]);
    assign we_act   = (we_v[p] == WE_HI[p]);
    assign rst_act  = (rst_v[p] == RST_HI[p]);
    assign wr_v[p]  = en_act & we_act;
    assign rd_v[p]  = en_act & ~rst_act;
    assign clr_v[p] = rst_act;

    dpram_wr_map #(.DATA_W(DATA_W), .PAR_W(PAR_W), .ROWS(ROWS)) i_map (
      .shape (shape_v[p]),
      .addr  (addr_v[p]),
      .din   (din_v[p]),
      .row   (row_v[p]),
      .level (lvl_v[p]),
      .slice (sub_v[p]),
      .dmask (dmask_v[p]),
      .dval  (dval_v[p]),
      .pmask (pmask_v[p]),
      .pval  (pval_v[p])
    );

    // Slice selection follows the read row register by one edge.
    always_ff @(posedge gclk) begin
      if (rst_act) begin
        lvl_q <= '0;
        sub_q <= '0;
      end else if (rd_v[p]) begin
        lvl_q <= lvl_v[p];
        sub_q <= sub_v[p];
      end
    end

    dpram_rd_extract #(.DATA_W(DATA_W), .PAR_W(PAR_W)) i_ext (
      .level (lvl_q),
      .slice (sub_q),
      .row_d (rdat_v[p]),
      .row_p (rpar_v[p]),
      .dout  (dout_v[p])
    );
  end

  dpram_store #(.DATA_W(DATA_W), .PAR_W(PAR_W), .ROWS(ROWS)) i_store (
    .clk     (gclk),
    .wr_a    (wr_v[0]),
    .rd_a    (rd_v[0]),
    .clr_a   (clr_v[0]),
    .row_a   (row_v[0]),
    .dmask_a (dmask_v[0]),
    .dval_a  (dval_v[0]),
    .pmask_a (pmask_v[0]),
    .pval_a  (pval_v[0]),
    .rdat_a  (rdat_v[0]),
    .rpar_a  (rpar_v[0]),
    .wr_b    (wr_v[1]),
    .rd_b    (rd_v[1]),
    .clr_b   (clr_v[1]),
    .row_b   (row_v[1]),
    .dmask_b (dmask_v[1]),
    .dval_b  (dval_v[1]),
    .pmask_b (pmask_v[1]),
    .pval_b  (pval_v[1]),
    .rdat_b  (rdat_v[1]),
    .rpar_b  (rpar_v[1])
  );
endmodule

// File: rtl/dpram_multi_shape_chk.sv
module dpram_multi_shape_chk #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PAR_W       = 4,
  parameter bit          CLK_FALLING = 1'b0,
  parameter bit          A_EN_HIGH   = 1'b1,
  parameter bit          A_RST_HIGH  = 1'b1,
  parameter bit          B_EN_HIGH   = 1'b1,
  parameter bit          B_RST_HIGH  = 1'b1
) (
  input logic                     clk,
  input logic                     a_en,
  input logic                     a_rst,
  input logic [2:0]               a_shape,
  input logic [DATA_W+PAR_W-1:0]  a_dout,
  input logic                     b_en,
  input logic                     b_rst,
  input logic [2:0]               b_shape,
  input logic [DATA_W+PAR_W-1:0]  b_dout
);
  localparam int unsigned PORT_W = DATA_W + PAR_W;
  localparam int unsigned NARROW = DATA_W >> 3;

  logic ck;
  logic seen_q = 1'b0;
  logic a_en_act, a_rst_act, b_en_act, b_rst_act;

  assign ck        = CLK_FALLING ? ~clk : clk;
  assign a_en_act  = (a_en == A_EN_HIGH);
  assign a_rst_act = (a_rst == A_RST_HIGH);
  assign b_en_act  = (b_en == B_EN_HIGH);
  assign b_rst_act = (b_rst == B_RST_HIGH);

  always_ff @(posedge ck) seen_q <= 1'b1;

  a_r7_clear_a: assert property (@(posedge ck) disable iff (!seen_q)
    $past(a_rst_act) |-> (a_dout == '0));
  a_r7_clear_b: assert property (@(posedge ck) disable iff (!seen_q)
    $past(b_rst_act) |-> (b_dout == '0));
  a_r6_hold_a: assert property (@(posedge ck) disable iff (!seen_q)
    $past(!a_en_act && !a_rst_act) |-> $stable(a_dout));
  a_r6_hold_b: assert property (@(posedge ck) disable iff (!seen_q)
    $past(!b_en_act && !b_rst_act) |-> $stable(b_dout));
  a_r2_narrow_a: assert property (@(posedge ck) disable iff (!seen_q)
    $past(a_en_act && !a_rst_act && (a_shape >= 3'd3)) |-> (a_dout[PORT_W-1:NARROW] == '0));
  a_r2_narrow_b: assert property (@(posedge ck) disable iff (!seen_q)
    $past(b_en_act && !b_rst_act && (b_shape >= 3'd3)) |-> (b_dout[PORT_W-1:NARROW] == '0));
endmodule

bind dpram_multi_shape dpram_multi_shape_chk #(
  .DATA_W(DATA_W), .PAR_W(PAR_W), .CLK_FALLING(CLK_FALLING),
  .A_EN_HIGH(A_EN_HIGH), .A_RST_HIGH(A_RST_HIGH),
  .B_EN_HIGH(B_EN_HIGH), .B_RST_HIGH(B_RST_HIGH)
) i_chk (
  .clk(clk), .a_en(a_en), .a_rst(a_rst), .a_shape(a_shape), .a_dout(a_dout),
  .b_en(b_en), .b_rst(b_rst), .b_shape(b_shape), .b_dout(b_dout)
);

// File: tb/test_dpram_multi_shape.sv
module test_dpram_multi_shape;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        a_en, a_we, a_rst, b_en, b_we, b_rst;
  logic [2:0]  a_shape, b_shape;
  logic [14:0] a_addr, b_addr;
  logic [35:0] a_din, b_din;
  logic [35:0] a_dout, b_dout;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  // Port B runs with active-low controls (R9).
  dpram_multi_shape #(.B_EN_HIGH(1'b0), .B_WE_HIGH(1'b0), .B_RST_HIGH(1'b0)) i_dpram_multi_shape (
    .clk(clk),
    .a_en(a_en), .a_we(a_we), .a_rst(a_rst), .a_shape(a_shape), .a_addr(a_addr),
    .a_din(a_din), .a_dout(a_dout),
    .b_en(b_en), .b_we(b_we), .b_rst(b_rst), .b_shape(b_shape), .b_addr(b_addr),
    .b_din(b_din), .b_dout(b_dout)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  ws;
    logic [14:0] wa;
    logic [35:0] wd;
    logic [2:0]  rs;
    logic [14:0] ra;
    logic [35:0] ex;
  } vec_t;

  // Write through port A (if wr), then read through port B and compare.
  localparam vec_t VECS [11] = '{
    '{1'b1, 3'd0, 15'd5,    36'hA12345678, 3'd0, 15'd5,   36'hA12345678}, // R1 R3 x36 both ways
    '{1'b0, 3'd0, 15'd0,    36'h0,         3'd2, 15'd21,  36'h000000156}, // R3 x9 byte1 + parity
    '{1'b0, 3'd0, 15'd0,    36'h0,         3'd1, 15'd11,  36'h000021234}, // R3 x18 upper half
    '{1'b0, 3'd0, 15'd0,    36'h0,         3'd3, 15'd47,  36'h000000001}, // R2 x4 top nibble
    '{1'b0, 3'd0, 15'd0,    36'h0,         3'd5, 15'd163, 36'h000000001}, // R3 x1 single bit
    '{1'b1, 3'd2, 15'd22,   36'h0000000CC, 3'd0, 15'd5,   36'hA12CC5678}, // R5 slice-only write
    '{1'b1, 3'd4, 15'd48,   36'h000000003, 3'd0, 15'd3,   36'h000000003}, // R1 x2 write
    '{1'b1, 3'd5, 15'd127,  36'h000000001, 3'd3, 15'd31,  36'h000000008}, // R3 x1 into bit 31
    '{1'b1, 3'd1, 15'd14,   36'h00001BEEF, 3'd2, 15'd28,  36'h0000001EF}, // R3 x18 write, x9 read
    '{1'b1, 3'd7, 15'd1000, 36'h000000001, 3'd4, 15'd500, 36'h000000001}, // R1 reserved code as x1
    '{1'b1, 3'd3, 15'd74,   36'h7000000F5, 3'd0, 15'd9,   36'h000000500}  // R2 upper din ignored
  };

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    a_en = 1'b0; a_we = 1'b0; a_rst = 1'b0;
    b_en = 1'b1; b_we = 1'b1; b_rst = 1'b1;
  endtask

  task automatic a_wr(input logic [2:0] s, input logic [14:0] ad, input logic [35:0] d);
    a_en = 1'b1; a_we = 1'b1; a_shape = s; a_addr = ad; a_din = d;
    cyc();
    idle();
  endtask

  task automatic a_rd(input logic [2:0] s, input logic [14:0] ad);
    a_en = 1'b1; a_we = 1'b0; a_shape = s; a_addr = ad;
    cyc();
    idle();
  endtask

  task automatic b_rd(input logic [2:0] s, input logic [14:0] ad);
    b_en = 1'b0; b_we = 1'b1; b_shape = s; b_addr = ad;
    cyc();
    idle();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    a_shape = 3'd0; a_addr = '0; a_din = '0;
    b_shape = 3'd0; b_addr = '0; b_din = '0;
    a_rst = 1'b1; b_rst = 1'b0;
    repeat (4) @(negedge clk);
    idle();
    check("R7 reset A", a_dout, 36'h0);
    check("R7 R9 reset B", b_dout, 36'h0);

    foreach (VECS[i]) begin
      if (VECS[i].wr) a_wr(VECS[i].ws, VECS[i].wa, VECS[i].wd);
      b_rd(VECS[i].rs, VECS[i].ra);
      check($sformatf("R3 vector %0d", i), b_dout, VECS[i].ex);
    end

    // R4: one-cycle read latency
    a_rd(3'd0, 15'd9);
    a_en = 1'b1; a_shape = 3'd0; a_addr = 15'd5;
    #(CLK_P/4);
    check("R4 before edge", a_dout, 36'h000000500);
    @(negedge clk);
    idle();
    check("R4 after edge", a_dout, 36'hA12CC5678);

    // R5: read during write gives old data
    a_wr(3'd0, 15'd5, 36'h3DEADBEEF);
    check("R5 old data on write", a_dout, 36'hA12CC5678);
    a_rd(3'd0, 15'd5);
    check("R5 new data", a_dout, 36'h3DEADBEEF);

    // R6: disabled port neither writes nor updates output
    a_rd(3'd0, 15'd9);
    a_en = 1'b0; a_we = 1'b1; a_shape = 3'd0; a_addr = 15'd5; a_din = '0;
    cyc();
    idle();
    check("R6 output held", a_dout, 36'h000000500);
    b_en = 1'b1; b_we = 1'b0; b_shape = 3'd0; b_addr = 15'd5; b_din = '0;
    cyc();
    idle();
    a_rd(3'd0, 15'd5);
    check("R6 R9 no write while disabled", a_dout, 36'h3DEADBEEF);

    // R7: reset clears output, memory kept
    a_en = 1'b1; a_rst = 1'b1; a_shape = 3'd0; a_addr = 15'd9;
    cyc();
    idle();
    check("R7 reset clears A", a_dout, 36'h0);
    a_rd(3'd0, 15'd5);
    check("R7 memory kept", a_dout, 36'h3DEADBEEF);
    b_rd(3'd0, 15'd5);
    b_rst = 1'b0;
    cyc();
    idle();
    check("R7 R9 active-low reset B", b_dout, 36'h0);

    // R8: write collision
    a_en = 1'b1; a_we = 1'b1; a_shape = 3'd0; a_addr = 15'd6; a_din = 36'h111111111;
    b_en = 1'b0; b_we = 1'b0; b_shape = 3'd2; b_addr = 15'd24; b_din = 36'h0000000AA;
    cyc();
    idle();
    a_rd(3'd0, 15'd6);
    check("R8 port A wins", a_dout, 36'h111111111);
    a_en = 1'b1; a_we = 1'b1; a_shape = 3'd2; a_addr = 15'd24; a_din = 36'h000000055;
    b_en = 1'b0; b_we = 1'b0; b_shape = 3'd2; b_addr = 15'd25; b_din = 36'h0000001AA;
    cyc();
    idle();
    a_rd(3'd0, 15'd6);
    check("R8 disjoint bits merge", a_dout, 36'h21111AA55);

    finish_run();
  end
endmodule